// File: doc/BRIEF.md
# Per-Stream Programmable Delay Bank

This block sits in front of a blending datapath. It gives each of five input streams its own extra latency of 0 to 7 clock cycles, so that streams arriving at different times line up before they are combined. The five streams are sample A, sample B, the blend factor, the number-format flag and the rounding select. Each stream runs through its own tapped register chain. A 3-bit length field chooses which tap drives that stream's output.

The five length fields together form one 15-bit configuration word. The word is written one bit at a time through a serial data pin and a load strobe. The strobe is sampled on the main clock, and only a rising edge of the strobe shifts in a bit. A bypass input clears the whole word, so every stream passes straight through. The blending arithmetic lives downstream and is not part of this block.

Top module: `stream_delay_bank`

## Requirements
- R1: The configuration word is 15 bits wide. Bits [2:0] set the delay of sample A, [5:3] sample B, [8:6] the blend factor, [11:9] the format flag and [14:12] the rounding select.
- R2: A field value d (0..7) makes the output of its stream equal that stream's input from exactly d clock edges earlier. A value of 0 passes the input to the output within the same cycle.
- R3: One bit is shifted in on each strobe rising edge, that is, when the strobe is sampled high at a clock edge after being sampled low at the edge before. The new bit enters at bit 14 and every other bit moves one place toward bit 0. After 15 rising edges, the first bit sent sits in bit 0 and the last bit sent sits in bit 14.
- R4: A strobe held high over several clock edges shifts only once. Without a strobe rising edge the configuration does not change.
- R5: While bypass is sampled high, the configuration is cleared to zero at the next edge, so every stream passes straight through, and strobe edges are ignored. After bypass falls, the configuration stays at zero until new bits are shifted in.
- R6: A synchronous active-high reset clears the configuration to zero, which makes every delay zero.
- R7: The five streams are independent. Each field changes the latency of its own stream only, and the maximum value 7 gives 7 cycles of delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bypass | input | 1 | Forces all delays to zero while high |
| cfg_bit | input | 1 | Serial configuration data |
| cfg_strobe | input | 1 | Serial load strobe; a rising edge shifts in cfg_bit |
| a_in | input | DATA_W | Sample A input |
| b_in | input | DATA_W | Sample B input |
| mix_in | input | MIX_W | Blend factor input |
| fmt_in | input | 1 | Number-format flag input |
| rnd_in | input | RND_W | Rounding select input |
| a_out | output | DATA_W | Delayed sample A |
| b_out | output | DATA_W | Delayed sample B |
| mix_out | output | MIX_W | Delayed blend factor |
| fmt_out | output | 1 | Delayed format flag |
| rnd_out | output | RND_W | Delayed rounding select |

## Verification
The assertions assume that the strobe is synchronous to the main clock and is held low through reset. Without that, the edge detector and the properties built on $rose of the strobe would see a rising edge that never happened. They also assume that the delay properties are judged only once the pipeline holds samples taken after reset, so they are gated on the reset history. The stimulus drives the strobe low for at least one full cycle between pulses. It holds the configuration steady for longer than the deepest chain before sampling the outputs, and it changes bypass only while no data check is in progress.

// File: rtl/dly_pkg.sv
package dly_pkg;
  localparam int FIELD_W     = 3;
  localparam int NUM_STREAMS = 5;
  localparam int CFG_W       = FIELD_W * NUM_STREAMS;
  localparam int MAX_DLY     = (1 << FIELD_W) - 1;

  // Field order matters: it sets the bit position of each field in the word.
  typedef enum int {
    ST_A   = 0,
    ST_B   = 1,
    ST_MIX = 2,
    ST_FMT = 3,
    ST_RND = 4
  } stream_e;

  function automatic int field_lsb(stream_e s);
    return int'(s) * FIELD_W;
  endfunction
endpackage

// File: rtl/ser_cfg_reg.sv
module ser_cfg_reg #(
  parameter int CFG_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bypass,
  input  logic             ser_bit,
  input  logic             ser_strobe,
  output logic [CFG_W-1:0] cfg
);
  logic strobe_q;
  logic strobe_rise;

  assign strobe_rise = ser_strobe & ~strobe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      cfg      <= '0;
    end else begin
      strobe_q <= ser_strobe;
      if (bypass)
        cfg <= '0;
      else if (strobe_rise)
        cfg <= {ser_bit, cfg[CFG_W-1:1]};
    end
  end

  // R5: bypass clears the word on the next edge
  p_bypass_clears_r5: assert property (@(posedge clk) disable iff (rst)
    bypass |=> (cfg == '0));

  // R3: a strobe rising edge inserts the serial bit at the top and moves the rest down
  p_shift_order_r3: assert property (@(posedge clk) disable iff (rst)
    ($rose(ser_strobe) && !bypass) |=>
      (cfg[CFG_W-1] == $past(ser_bit)) && (cfg[CFG_W-2:0] == $past(cfg[CFG_W-1:1])));

  // R4: without a strobe rising edge the word holds
  p_hold_without_edge_r4: assert property (@(posedge clk) disable iff (rst)
    (!$rose(ser_strobe) && !bypass) |=> $stable(cfg));
endmodule

// File: rtl/tap_delay_line.sv
module tap_delay_line #(
  parameter int W     = 12,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     dout
);
  localparam int DEPTH = (1 << SEL_W) - 1;

  logic [W-1:0] stg [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= din;
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_chain
    always_ff @(posedge clk) begin
      if (rst) stg[k] <= '0;
      else     stg[k] <= stg[k-1];
    end
  end

  always_comb begin
    if (sel == '0) dout = din;
    else           dout = stg[sel - SEL_W'(1)];
  end

  // R2: a setting of one gives the previous cycle's input
  p_one_stage_r2: assert property (@(posedge clk) disable iff (rst)
    ((sel == SEL_W'(1)) && !$past(rst)) |-> (dout == $past(din)));

  // R2: a setting of two gives the input from two edges back
  p_two_stage_r2: assert property (@(posedge clk) disable iff (rst)
    ((sel == SEL_W'(2)) && !$past(rst) && !$past(rst, 2)) |-> (dout == $past(din, 2)));
endmodule

// File: rtl/stream_delay_bank.sv
module stream_delay_bank
  import dly_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int MIX_W  = 12,
  parameter int RND_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bypass,
  input  logic              cfg_bit,
  input  logic              cfg_strobe,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic [MIX_W-1:0]  mix_in,
  input  logic              fmt_in,
  input  logic [RND_W-1:0]  rnd_in,
  output logic [DATA_W-1:0] a_out,
  output logic [DATA_W-1:0] b_out,
  output logic [MIX_W-1:0]  mix_out,
  output logic              fmt_out,
  output logic [RND_W-1:0]  rnd_out
);
  localparam int LSB_A   = field_lsb(ST_A);
  localparam int LSB_B   = field_lsb(ST_B);
  localparam int LSB_MIX = field_lsb(ST_MIX);
  localparam int LSB_FMT = field_lsb(ST_FMT);
  localparam int LSB_RND = field_lsb(ST_RND);

  logic [CFG_W-1:0] cfg;

  ser_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .bypass     (bypass),
    .ser_bit    (cfg_bit),
    .ser_strobe (cfg_strobe),
    .cfg        (cfg)
  );

  tap_delay_line #(.W(DATA_W), .SEL_W(FIELD_W)) u_dl_a (
    .clk(clk), .rst(rst), .sel(cfg[LSB_A +: FIELD_W]), .din(a_in), .dout(a_out));

  tap_delay_line #(.W(DATA_W), .SEL_W(FIELD_W)) u_dl_b (
    .clk(clk), .rst(rst), .sel(cfg[LSB_B +: FIELD_W]), .din(b_in), .dout(b_out));

  tap_delay_line #(.W(MIX_W), .SEL_W(FIELD_W)) u_dl_mix (
    .clk(clk), .rst(rst), .sel(cfg[LSB_MIX +: FIELD_W]), .din(mix_in), .dout(mix_out));

  tap_delay_line #(.W(1), .SEL_W(FIELD_W)) u_dl_fmt (
    .clk(clk), .rst(rst), .sel(cfg[LSB_FMT +: FIELD_W]), .din(fmt_in), .dout(fmt_out));

  tap_delay_line #(.W(RND_W), .SEL_W(FIELD_W)) u_dl_rnd (
    .clk(clk), .rst(rst), .sel(cfg[LSB_RND +: FIELD_W]), .din(rnd_in), .dout(rnd_out));

  // R5: one cycle after bypass is sampled, every stream passes through
  p_bypass_passthru_r5: assert property (@(posedge clk) disable iff (rst)
    $past(bypass) |-> ((a_out == a_in) && (b_out == b_in) && (mix_out == mix_in)
                       && (fmt_out == fmt_in) && (rnd_out == rnd_in)));

  // R6: after reset every stream passes through until the word is loaded
  p_reset_passthru_r6: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ((a_out == a_in) && (b_out == b_in) && (mix_out == mix_in)));
endmodule

// File: tb/tb_stream_delay_bank.sv
module tb_stream_delay_bank;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;
  localparam int MW = 12;
  localparam int RW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bypass = 1'b0;
  logic          cfg_bit = 1'b0;
  logic          cfg_strobe = 1'b0;
  logic [DW-1:0] a_in, b_in;
  logic [MW-1:0] mix_in;
  logic          fmt_in;
  logic [RW-1:0] rnd_in;
  logic [DW-1:0] a_out, b_out;
  logic [MW-1:0] mix_out;
  logic          fmt_out;
  logic [RW-1:0] rnd_out;

  int t = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  stream_delay_bank dut (
    .clk(clk), .rst(rst), .bypass(bypass), .cfg_bit(cfg_bit), .cfg_strobe(cfg_strobe),
    .a_in(a_in), .b_in(b_in), .mix_in(mix_in), .fmt_in(fmt_in), .rnd_in(rnd_in),
    .a_out(a_out), .b_out(b_out), .mix_out(mix_out), .fmt_out(fmt_out), .rnd_out(rnd_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [11:0] pat(int s, int n);
    case (s)
      0: return 12'((n * 37) + 5);
      1: return 12'((n * 91) + 3);
      2: return 12'((n * 13) + 1000);
      3: return 12'((n / 2) % 2);
      default: return 12'(((n * 3) + (n / 5)) % 4);
    endcase
  endfunction

  // Inputs change on the falling edge; the value seen at index n is pat(s, n)
  initial begin
    a_in = pat(0, 0); b_in = pat(1, 0); mix_in = pat(2, 0);
    fmt_in = pat(3, 0) != 0; rnd_in = RW'(pat(4, 0));
  end
  always @(negedge clk) begin
    t      <= t + 1;
    a_in   <= pat(0, t + 1);
    b_in   <= pat(1, t + 1);
    mix_in <= pat(2, t + 1);
    fmt_in <= pat(3, t + 1) != 0;
    rnd_in <= RW'(pat(4, t + 1));
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Compare every stream against its input from the given number of cycles back
  task automatic check_delays(string req, int da, int db, int dm, int df, int dr);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk(req, "a_out",   int'(a_out),   int'(pat(0, t - da)));
      chk(req, "b_out",   int'(b_out),   int'(pat(1, t - db)));
      chk(req, "mix_out", int'(mix_out), int'(pat(2, t - dm)));
      chk(req, "fmt_out", int'(fmt_out), int'(pat(3, t - df)));
      chk(req, "rnd_out", int'(rnd_out), int'(pat(4, t - dr)));
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // Shift bits lsb first; each strobe is held high for 'hold' cycles
  task automatic send_bits(logic [14:0] v, int nbits, int hold);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      cfg_bit = v[i];
      cfg_strobe = 1'b1;
      repeat (hold) @(negedge clk);
      cfg_strobe = 1'b0;
    end
    @(negedge clk);
  endtask

  function automatic logic [14:0] mkcfg(int da, int db, int dm, int df, int dr);
    // R1: A at [2:0], B at [5:3], blend at [8:6], format at [11:9], round at [14:12]
    return {3'(dr), 3'(df), 3'(dm), 3'(db), 3'(da)};
  endfunction

  task automatic t_reset_state();
    wait_cyc(2);
    check_delays("R6 reset", 0, 0, 0, 0, 0);
  endtask

  task automatic t_distinct_fields();
    send_bits(mkcfg(3, 4, 7, 1, 5), 15, 1);
    wait_cyc(10);
    check_delays("R1 R2 R7 distinct", 3, 4, 7, 1, 5);
  endtask

  task automatic t_only_b();
    send_bits(15'b000_000_000_100_000, 15, 1);
    wait_cyc(10);
    check_delays("R1 R7 field B only", 0, 4, 0, 0, 0);
  endtask

  task automatic t_all_max();
    send_bits(mkcfg(7, 7, 7, 7, 7), 15, 1);
    wait_cyc(10);
    check_delays("R7 max", 7, 7, 7, 7, 7);
  endtask

  task automatic t_long_strobe();
    send_bits(mkcfg(2, 6, 1, 3, 0), 15, 3);
    wait_cyc(10);
    check_delays("R4 long strobe", 2, 6, 1, 3, 0);
    // no strobe activity: configuration must stay
    wait_cyc(20);
    check_delays("R4 hold", 2, 6, 1, 3, 0);
  endtask

  task automatic t_partial_shift();
    logic [14:0] base;
    logic [14:0] exp;
    base = mkcfg(1, 2, 3, 4, 5);
    send_bits(base, 15, 1);
    // R3: three more ones enter at bit 14 and push the word toward bit 0
    send_bits(15'b111, 3, 1);
    exp = {3'b111, base[14:3]};
    wait_cyc(10);
    check_delays("R3 partial shift", int'(exp[2:0]), int'(exp[5:3]), int'(exp[8:6]),
                 int'(exp[11:9]), int'(exp[14:12]));
  endtask

  task automatic t_bypass();
    send_bits(mkcfg(5, 3, 2, 6, 4), 15, 1);
    wait_cyc(10);
    @(negedge clk); bypass = 1'b1;
    wait_cyc(2);
    check_delays("R5 bypass on", 0, 0, 0, 0, 0);
    send_bits(15'h7FFF, 6, 1);
    check_delays("R5 strobes ignored", 0, 0, 0, 0, 0);
    @(negedge clk); bypass = 1'b0;
    wait_cyc(10);
    check_delays("R5 after bypass", 0, 0, 0, 0, 0);
  endtask

  task automatic t_reset_clears();
    send_bits(mkcfg(7, 1, 4, 2, 3), 15, 1);
    wait_cyc(10);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    wait_cyc(2);
    check_delays("R6 reset clears", 0, 0, 0, 0, 0);
  endtask

  task automatic t_zero_load();
    send_bits(mkcfg(6, 6, 6, 6, 6), 15, 1);
    send_bits(15'h0000, 15, 1);
    wait_cyc(3);
    check_delays("R2 zero passthru", 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst = 1'b0;
    t_reset_state();
    t_distinct_fields();
    t_only_b();
    t_all_max();
    t_long_strobe();
    t_partial_shift();
    t_bypass();
    t_reset_clears();
    t_zero_load();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule